// File: doc/BRIEF.md
# Register access errata sequencer

This block sits between a host port that asks for single register reads and writes and the internal register space of a device whose early silicon revision can hang when its registers are touched directly. For every accepted request it issues, on a single-outstanding request/acknowledge bus, an optional dummy read before the real access, then the real read or write, then one or two dummy reads after it. The real access's read data goes back to the host together with a one-cycle done pulse.

The dummy sequence is used only when the errata-enable input is high at the moment the request is accepted and the target offset is below 0x45000. Every other request passes through as one bus access. The dummy before the real access has its address chosen by decoding the target offset. The dummies after it are an extra read of 0x38, used only for target 0x100, followed by a read of 0xB050 in every case.

Top module: `erratum_access_seq`

## Requirements
- R1: When errata_en is low at acceptance, the request produces exactly one downstream access, to req_addr, with req_write and req_wdata as given.
- R2: A request with req_addr at or above 0x45000 produces exactly one downstream access, even when errata_en is high.
- R3: For a qualifying request (errata_en high and req_addr below 0x45000), the first access is a dummy read. Its address is 0xC0 for targets 0x0 and 0x80, 0x28 for targets 0x148 and 0x200, and 0x158 for any other target.
- R4: For a qualifying request to target 0x100 only, a dummy read of 0x38 comes right after the real access.
- R5: Every qualifying request ends with a dummy read of 0xB050.
- R6: Dummy accesses drive dn_write=0 and dn_wdata=0. rdata is loaded only from dn_rdata at the acknowledge of a real read, and it keeps its value through dummies and writes.
- R7: Accesses go out strictly in the order pre-dummy, real access, post-dummies. Each one holds dn_req, dn_addr and dn_write steady until dn_ack, and only one is outstanding at a time.
- R8: req_ready is low from the cycle after acceptance until the final acknowledge. done is high for exactly one cycle, the cycle after the final acknowledge, with req_ready high and dn_req low in that cycle.
- R9: After reset: req_ready=1, done=0, dn_req=0, rdata=0.
- R10: The real access drives dn_write=req_write, and dn_wdata=req_wdata for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| errata_en | input | 1 | Turns on the dummy-access workaround, sampled at acceptance |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Target register offset |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data from the last real read |
| dn_req | output | 1 | Downstream access request |
| dn_write | output | 1 | Downstream write strobe |
| dn_addr | output | ADDR_W | Downstream offset |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | DATA_W | Downstream read data, valid with dn_ack |

## Verification
The bench builds the block with its default 27-bit offsets and 64-bit data. These are the real widths, so the bench can send every decoded offset, the last offsets on each side of the 0x45000 limit and the top of the address space. It sweeps these targets across both errata settings, reads and writes, and acknowledge delays of zero to two cycles. For each request it compares the whole downstream access list against a list it builds itself from the decode rules, and it checks that rdata holds its value across writes.

// File: rtl/erq_pkg.sv
// Shared definitions for the errata access sequencer.
// Assumes offsets fit in 32 bits before being cast to the bus width.
package erq_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_REAL = 3'd2,
        S_MID  = 3'd3,
        S_FIN  = 3'd4
    } step_e;

    localparam logic [31:0] WAR_LIMIT   = 32'h0004_5000;
    localparam logic [31:0] PRE_A_ADDR  = 32'h0000_00C0;
    localparam logic [31:0] PRE_B_ADDR  = 32'h0000_0028;
    localparam logic [31:0] PRE_C_ADDR  = 32'h0000_0158;
    localparam logic [31:0] MID_TARGET  = 32'h0000_0100;
    localparam logic [31:0] MID_ADDR    = 32'h0000_0038;
    localparam logic [31:0] FIN_ADDR    = 32'h0000_B050;
endpackage

// File: rtl/erq_plan.sv
// Decodes a target offset into the dummy-access plan: whether the
// workaround applies, which pre-access dummy offset to use and whether
// the extra post-access dummy is needed. Purely combinational.
module erq_plan
    import erq_pkg::*;
#(
    parameter int ADDR_W = 27
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              qual,
    output logic [ADDR_W-1:0] pre_addr,
    output logic              mid_need
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WAR_LIMIT);

    // Workaround qualification and post-dummy need.
    always_comb begin
        qual     = en && (addr < LIMIT);
        mid_need = (addr == ADDR_W'(MID_TARGET));
    end

    // Pre-access dummy offset selection by target offset.
    always_comb begin
        if (addr == '0 || addr == ADDR_W'(32'h80))
            pre_addr = ADDR_W'(PRE_A_ADDR);
        else if (addr == ADDR_W'(32'h148) || addr == ADDR_W'(32'h200))
            pre_addr = ADDR_W'(PRE_B_ADDR);
        else
            pre_addr = ADDR_W'(PRE_C_ADDR);
    end
endmodule

// File: rtl/erq_ctrl.sv
// Step sequencer: accepts one request, walks the steps pre-dummy, real,
// optional mid-dummy and final dummy on a single-outstanding bus, and
// pulses done after the last acknowledge. Assumes the bus acknowledges
// only while dn_req is high.
module erq_ctrl
    import erq_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              plan_qual,
    input  logic [ADDR_W-1:0] plan_pre,
    input  logic              plan_mid,
    output logic              req_ready,
    output logic              done,
    output logic              dn_req,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ack,
    output logic              cap_en
);
    step_e             st;
    logic              wr_q;
    logic              qual_q;
    logic              mid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pre_q;
    logic [DATA_W-1:0] wdata_q;

    // Step register, request latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            done    <= 1'b0;
            wr_q    <= 1'b0;
            qual_q  <= 1'b0;
            mid_q   <= 1'b0;
            addr_q  <= '0;
            pre_q   <= '0;
            wdata_q <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    wr_q    <= req_write;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    qual_q  <= plan_qual;
                    mid_q   <= plan_mid;
                    pre_q   <= plan_pre;
                    st      <= plan_qual ? S_PRE : S_REAL;
                end
                S_PRE: if (dn_ack) st <= S_REAL;
                S_REAL: if (dn_ack) begin
                    if (!qual_q) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= mid_q ? S_MID : S_FIN;
                    end
                end
                S_MID: if (dn_ack) st <= S_FIN;
                S_FIN: if (dn_ack) begin
                    st   <= S_IDLE;
                    done <= 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Downstream drive for the current step; dummies are plain reads.
    always_comb begin
        req_ready = (st == S_IDLE);
        dn_req    = (st != S_IDLE);
        dn_write  = (st == S_REAL) && wr_q;
        dn_wdata  = ((st == S_REAL) && wr_q) ? wdata_q : '0;
        case (st)
            S_PRE:   dn_addr = pre_q;
            S_MID:   dn_addr = ADDR_W'(MID_ADDR);
            S_FIN:   dn_addr = ADDR_W'(FIN_ADDR);
            default: dn_addr = addr_q;
        endcase
        cap_en = (st == S_REAL) && dn_ack && !wr_q;
    end

    // R7: an access is held steady until acknowledged.
    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_write)));

    // R8: done lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: an unqualified request ends at its real access.
    assert_single_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_REAL && dn_ack && !qual_q) |=> (!dn_req && done));

    // R7: after the pre-dummy acknowledge the real target follows.
    assert_pre_then_real_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRE && dn_ack) |=> (dn_addr == addr_q));
endmodule

// File: rtl/erq_rdcap.sv
// Read data holding register: loads the downstream data only when the
// real read is acknowledged. Assumes cap_en is a single-cycle strobe.
module erq_rdcap #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    // Capture real read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cap_en) rdata <= din;
    end
endmodule

// File: rtl/erratum_access_seq.sv
// Top of the errata access sequencer: plan decode of the incoming request,
// step sequencer on the downstream bus and the read data register.
// Assumes errata_en is sampled together with an accepted request.
module erratum_access_seq
    import erq_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              errata_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              dn_req,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata
);
    logic              plan_qual;
    logic              plan_mid;
    logic [ADDR_W-1:0] plan_pre;
    logic              cap_en;

    erq_plan #(.ADDR_W(ADDR_W)) u_plan (
        .en       (errata_en),
        .addr     (req_addr),
        .qual     (plan_qual),
        .pre_addr (plan_pre),
        .mid_need (plan_mid)
    );

    erq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .plan_qual (plan_qual),
        .plan_pre  (plan_pre),
        .plan_mid  (plan_mid),
        .req_ready (req_ready),
        .done      (done),
        .dn_req    (dn_req),
        .dn_write  (dn_write),
        .dn_addr   (dn_addr),
        .dn_wdata  (dn_wdata),
        .dn_ack    (dn_ack),
        .cap_en    (cap_en)
    );

    erq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (dn_rdata),
        .rdata  (rdata)
    );

    // R8: when done is high the block is idle and ready.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !dn_req));

    // R6: rdata only moves right after a real read acknowledge.
    assert_rdata_real_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> $past(cap_en));
endmodule

// File: tb/erratum_access_seq_tb.sv
module erratum_access_seq_tb;
    localparam int AW = 27;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          errata_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done, dn_req, dn_write;
    logic [DW-1:0] rdata, dn_wdata;
    logic [AW-1:0] dn_addr;
    logic          dn_ack = 1'b0;
    logic [DW-1:0] dn_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int wcnt = 0;
    int logn = 0;
    int cyc = 0;
    logic [AW-1:0] lg_addr [8];
    logic          lg_wr   [8];
    logic [DW-1:0] lg_wd   [8];
    logic [DW-1:0] last_rd = '0;

    erratum_access_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .errata_en(errata_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rdata(rdata), .dn_req(dn_req), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
        .dn_rdata(dn_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rd_pat(logic [AW-1:0] a);
        return 64'hFEED_0000_0000_0000 ^ {37'h0, a} ^ ({37'h0, a} << 29);
    endfunction

    function automatic logic [AW-1:0] sweep_addr(int i);
        case (i)
            0: return 27'h0;       1: return 27'h80;
            2: return 27'h148;     3: return 27'h200;
            4: return 27'h100;     5: return 27'h158;
            6: return 27'h8;       7: return 27'h44FF8;
            8: return 27'h45000;   9: return 27'h45008;
            10: return 27'h7FFFFF8;
            default: return 27'hC0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Downstream responder: acknowledges after lat idle cycles and logs accesses.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (dn_ack) dn_ack = 1'b0;
            else if (rst_n && dn_req) begin
                if (wcnt >= lat) begin
                    dn_ack = 1'b1;
                    dn_rdata = rd_pat(dn_addr);
                    if (logn < 8) begin
                        lg_addr[logn] = dn_addr;
                        lg_wr[logn] = dn_write;
                        lg_wd[logn] = dn_wdata;
                    end
                    logn++;
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_run();
    end

    task automatic run_one(input logic en, input logic wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd);
        logic [AW-1:0] ex_addr [4];
        logic          ex_wr   [4];
        logic [DW-1:0] ex_wd   [4];
        int  exn;
        int  tmo;
        bit  rdy_bad;
        bit  qual;
        string rq;
        qual = en && (a < 27'h45000);
        rq = !en ? "R1" : (qual ? "R3" : "R2");
        exn = 0;
        if (qual) begin
            ex_addr[0] = (a == 27'h0 || a == 27'h80) ? 27'hC0 :
                         (a == 27'h148 || a == 27'h200) ? 27'h28 : 27'h158;
            ex_wr[0] = 1'b0; ex_wd[0] = '0; exn = 1;
        end
        ex_addr[exn] = a; ex_wr[exn] = wr; ex_wd[exn] = wr ? wd : '0; exn++;
        if (qual && a == 27'h100) begin
            ex_addr[exn] = 27'h38; ex_wr[exn] = 1'b0; ex_wd[exn] = '0; exn++;
        end
        if (qual) begin
            ex_addr[exn] = 27'hB050; ex_wr[exn] = 1'b0; ex_wd[exn] = '0; exn++;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        logn = 0;
        errata_en = en; req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_bad = 1'b0;
        tmo = 0;
        while (!done && tmo < 100) begin
            if (req_ready) rdy_bad = 1'b1;
            @(negedge clk);
            tmo++;
        end
        check(tmo < 100, "R8", "done seen", DW'(tmo), 64'd100);
        check(!rdy_bad, "R8", "ready low while busy", DW'(rdy_bad), 64'd0);
        check(req_ready && !dn_req, "R8", "idle at done", DW'({req_ready, dn_req}), 64'h2);
        check(logn == exn, rq, "access count", DW'(logn), DW'(exn));
        for (int k = 0; k < exn && k < logn && k < 8; k++) begin
            string rk;
            rk = (k == exn - 1 && qual) ? "R5" :
                 (qual && k == 2 && a == 27'h100) ? "R4" :
                 (ex_addr[k] == a && (k == 0) == !qual) ? rq : "R7";
            if (qual && k == 0) rk = "R3";
            check(lg_addr[k] == ex_addr[k], rk, "access addr", DW'(lg_addr[k]), DW'(ex_addr[k]));
            check(lg_wr[k] == ex_wr[k], (ex_addr[k] == a) ? "R10" : "R6", "access dir",
                  DW'(lg_wr[k]), DW'(ex_wr[k]));
            if (ex_wr[k] || ex_addr[k] != a)
                check(lg_wd[k] == ex_wd[k], (ex_addr[k] == a) ? "R10" : "R6", "access wdata",
                      lg_wd[k], ex_wd[k]);
        end
        if (!wr) last_rd = rd_pat(a);
        check(rdata == last_rd, "R6", "rdata", rdata, last_rd);
        @(negedge clk);
        check(!done, "R8", "done one cycle", DW'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0 && dn_req == 1'b0, "R9", "reset outputs",
              DW'({req_ready, done, dn_req}), 64'h4);
        check(rdata == '0, "R9", "reset rdata", rdata, '0);
        rst_n = 1'b1;
        for (int l = 0; l < 3; l++) begin
            lat = l;
            for (int e = 0; e < 2; e++)
                for (int w = 0; w < 2; w++)
                    for (int i = 0; i < 12; i++) begin
                        logic [AW-1:0] a;
                        a = sweep_addr(i);
                        run_one(e[0], w[0], a,
                                64'h1234_5678_9ABC_DEF0 ^ {37'h0, a} ^ (64'(l * 7 + i) << 40));
                    end
        end
        finish_run();
    end
endmodule